// File: doc/BRIEF.md
# I2C Target with Own-Address and General-Call Recognition

This block is the target (slave) side of a two-wire serial bus. It oversamples the clock line and the data line with the system clock, finds START and STOP conditions, and shifts in bytes most significant bit first. The first byte after a START is the address. The block compares it against a programmable own address, given either as a 7-bit value or as a 10-bit value sent in two bytes. It can also answer the all-zero broadcast address. Once addressed, it either receives data bytes and hands them to local logic, or sends bytes that local logic supplies. The R/W bit of the address byte picks the direction.

The block is always a target: it never generates START, STOP or clock pulses. The data line is open-drain. The block only ever pulls it low or lets it float, and it changes the line only while the clock line is low. Received bytes leave through a valid/ready pair. Bytes to send enter through a valid/ready pair, and the block pulls each byte when it needs it. Status outputs show whether a transfer is under way on the bus, whether the block has been addressed, the direction and whether the broadcast address was hit.

The data-line output `sda_oe` means "pull low". The bus line seen by the block is the wired-AND of every driver on the bus.

Top module: `i2c_tgt`

## Requirements
- R1: After reset, `sda_oe`, `st_busy`, `st_addressed`, `st_read`, `st_gc`, `rx_valid` and `tx_ready` are all 0.
- R2: With `cfg_addr10` = 0, the first byte after a START is acknowledged only when its bits 7..1 equal `cfg_own_addr[6:0]`. Acknowledged means the block pulls SDA low in the ninth clock. Bit 0 of that byte is R/W, where 1 means the bus controller reads. Every other first byte is left unacknowledged, with SDA released.
- R3: A first byte of 8'h00 is acknowledged when `cfg_gc_en` = 1, in either addressing mode, and then `st_gc` reads 1. With `cfg_gc_en` = 0 that byte is left unacknowledged, unless it matches the own address under R2.
- R4: With `cfg_addr10` = 1, a first byte of the form 11110, `cfg_own_addr[9:8]`, 0 is acknowledged. The next byte is then acknowledged only when it equals `cfg_own_addr[7:0]`, and only then does `st_addressed` read 1. Any other first byte is left unacknowledged, apart from R3 and R5.
- R5: With `cfg_addr10` = 1, a first byte of the form 11110, `cfg_own_addr[9:8]`, 1 is acknowledged only after a complete two-byte 10-bit match earlier in the same transfer, with a repeated START and no STOP in between. The block then acts as transmitter, and `st_read` reads 1.
- R6: When addressed for writing, each data byte (MSB first) is put on `rx_data` with `rx_valid` = 1. Both are held until `rx_ready` = 1 at a clock edge. A byte that completes while `rx_valid` is still 1 is dropped and left unacknowledged.
- R7: When addressed for reading, each byte is sent MSB first. If `tx_valid` = 1 when a byte is due, `tx_data` is taken and `tx_ready` pulses for one clock; otherwise 8'hFF is sent. After the bus controller acknowledges a byte (SDA low in the ninth clock), the next byte follows. After it leaves a byte unacknowledged, the block releases SDA and takes no more bytes until the next START.
- R8: With `cfg_ack_en` = 0, SDA stays released in every ninth clock. Address matching, `st_addressed` and data capture into `rx_data` are otherwise unchanged.
- R9: A START at any point, including in the middle of a byte, clears `st_addressed` and restarts address matching. A STOP at any point sets `st_busy`, `st_addressed` and `sda_oe` to 0, and the block captures no partial byte.
- R10: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, which oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| cfg_own_addr | input | 10 | Own address; bits 6..0 are used in 7-bit mode |
| cfg_addr10 | input | 1 | 1 selects 10-bit own-address matching |
| cfg_gc_en | input | 1 | 1 enables a response to address 8'h00 |
| cfg_ack_en | input | 1 | 1 allows the block to pull SDA low in the ninth clock |
| rx_data | output | 8 | Received data byte |
| rx_valid | output | 1 | `rx_data` holds an unread byte |
| rx_ready | input | 1 | Local logic takes the byte on `rx_data` |
| tx_data | input | 8 | Next byte to send |
| tx_valid | input | 1 | `tx_data` is available |
| tx_ready | output | 1 | One-clock pulse when `tx_data` is taken |
| st_busy | output | 1 | A START has been seen with no STOP since |
| st_addressed | output | 1 | The block is the addressed target in this transfer |
| st_read | output | 1 | The addressed direction is read (block transmits) |
| st_gc | output | 1 | The current transfer was addressed with 8'h00 |

## Verification
The hardest state to reach is the 10-bit read. The read header is only accepted after a complete two-byte write match, followed by a repeated START with no STOP in between. Reaching it takes a bench bus-controller model that can issue a START from an active transfer while the clock line is low. The same model produces a START and a STOP part-way through a data byte, which exercises the abort paths. It also holds `rx_ready` low across two data bytes, so that the second byte arrives while the first is still unread and the dropped-byte case is reached.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 10;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RXB,
    PH_ACK,
    PH_TXB,
    PH_MACK
  } phase_t;

  typedef enum logic [1:0] {
    K_ADDR1,
    K_ADDR2,
    K_DATA
  } kind_t;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_c;
  logic [STAGES-1:0] sda_c;
  logic              scl_d;
  logic              sda_d;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_c[g] <= 1'b1;
          sda_c[g] <= 1'b1;
        end else if (g == 0) begin
          scl_c[g] <= scl_i;
          sda_c[g] <= sda_i;
        end else begin
          scl_c[g] <= scl_c[(g > 0) ? g - 1 : 0];
          sda_c[g] <= sda_c[(g > 0) ? g - 1 : 0];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_c[STAGES-1];
      sda_d <= sda_c[STAGES-1];
    end
  end

  assign scl_s     = scl_c[STAGES-1];
  assign sda_s     = sda_c[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_tgt_match.sv
module i2c_tgt_match
  import i2c_tgt_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_in,
  input  kind_t             kind,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              addr10,
  input  logic              gc_en,
  input  logic              ten_ok,
  output logic              hit,
  output logic              want2,
  output logic              is_gc,
  output logic              is_rd
);
  localparam logic [4:0] HDR10 = 5'b11110;

  always_comb begin
    hit   = 1'b0;
    want2 = 1'b0;
    is_gc = 1'b0;
    is_rd = 1'b0;
    case (kind)
      K_ADDR1: begin
        if (gc_en && byte_in == '0) begin
          hit   = 1'b1;
          is_gc = 1'b1;
        end else if (!addr10) begin
          hit   = (byte_in[7:1] == own_addr[6:0]);
          is_rd = byte_in[0];
        end else if (byte_in[7:3] == HDR10 && byte_in[2:1] == own_addr[9:8]) begin
          if (!byte_in[0]) begin
            hit   = 1'b1;
            want2 = 1'b1;
          end else begin
            hit   = ten_ok;
            is_rd = 1'b1;
          end
        end
      end
      K_ADDR2: hit = (byte_in == own_addr[7:0]);
      default: ;
    endcase
  end
endmodule

// File: rtl/i2c_tgt.sv
module i2c_tgt
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] cfg_own_addr,
  input  logic              cfg_addr10,
  input  logic              cfg_gc_en,
  input  logic              cfg_ack_en,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              st_busy,
  output logic              st_addressed,
  output logic              st_read,
  output logic              st_gc
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  phase_t            phase;
  kind_t             kind;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] txsh;
  logic              ten_ok;
  logic              mack;
  logic              m_hit, m_want2, m_gc, m_rd;
  logic [BYTE_W-1:0] tx_pick;

  i2c_tgt_match u_match (
    .byte_in(sh), .kind(kind), .own_addr(cfg_own_addr), .addr10(cfg_addr10),
    .gc_en(cfg_gc_en), .ten_ok(ten_ok),
    .hit(m_hit), .want2(m_want2), .is_gc(m_gc), .is_rd(m_rd)
  );

  always_comb tx_pick = tx_valid ? tx_data : {BYTE_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase        <= PH_IDLE;
      kind         <= K_ADDR1;
      cnt          <= '0;
      sh           <= '0;
      txsh         <= '0;
      ten_ok       <= 1'b0;
      mack         <= 1'b0;
      sda_oe       <= 1'b0;
      rx_data      <= '0;
      rx_valid     <= 1'b0;
      tx_ready     <= 1'b0;
      st_busy      <= 1'b0;
      st_addressed <= 1'b0;
      st_read      <= 1'b0;
      st_gc        <= 1'b0;
    end else begin
      tx_ready <= 1'b0;
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (start_det) begin
        phase        <= PH_RXB;
        kind         <= K_ADDR1;
        cnt          <= '0;
        sda_oe       <= 1'b0;
        st_busy      <= 1'b1;
        st_addressed <= 1'b0;
        st_read      <= 1'b0;
        st_gc        <= 1'b0;
      end else if (stop_det) begin
        phase        <= PH_IDLE;
        sda_oe       <= 1'b0;
        ten_ok       <= 1'b0;
        st_busy      <= 1'b0;
        st_addressed <= 1'b0;
        st_read      <= 1'b0;
        st_gc        <= 1'b0;
      end else begin
        case (phase)
          PH_RXB: begin
            if (scl_rise) begin
              sh  <= {sh[BYTE_W-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == CNT_W'(BYTE_W)) begin
              case (kind)
                K_ADDR1: begin
                  if (!(m_hit && m_rd)) ten_ok <= 1'b0;
                  if (m_hit) begin
                    phase        <= PH_ACK;
                    sda_oe       <= cfg_ack_en;
                    st_addressed <= !m_want2;
                    st_read      <= m_rd;
                    st_gc        <= m_gc;
                    kind         <= m_want2 ? K_ADDR2 : K_DATA;
                  end else begin
                    phase <= PH_IDLE;
                  end
                end
                K_ADDR2: begin
                  if (m_hit) begin
                    phase        <= PH_ACK;
                    sda_oe       <= cfg_ack_en;
                    st_addressed <= 1'b1;
                    ten_ok       <= 1'b1;
                    kind         <= K_DATA;
                  end else begin
                    phase <= PH_IDLE;
                  end
                end
                default: begin
                  phase <= PH_ACK;
                  if (!rx_valid) begin
                    rx_data  <= sh;
                    rx_valid <= 1'b1;
                    sda_oe   <= cfg_ack_en;
                  end
                end
              endcase
            end
          end
          PH_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (kind == K_DATA && st_read) begin
                phase    <= PH_TXB;
                txsh     <= tx_pick;
                sda_oe   <= ~tx_pick[BYTE_W-1];
                tx_ready <= tx_valid;
                cnt      <= CNT_W'(1);
              end else begin
                phase  <= PH_RXB;
                sda_oe <= 1'b0;
              end
            end
          end
          PH_TXB: begin
            if (scl_fall) begin
              if (cnt == CNT_W'(BYTE_W)) begin
                sda_oe <= 1'b0;
                phase  <= PH_MACK;
              end else begin
                txsh   <= {txsh[BYTE_W-2:0], 1'b0};
                sda_oe <= ~txsh[BYTE_W-2];
                cnt    <= cnt + 1'b1;
              end
            end
          end
          PH_MACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                phase    <= PH_TXB;
                txsh     <= tx_pick;
                sda_oe   <= ~tx_pick[BYTE_W-1];
                tx_ready <= tx_valid;
                cnt      <= CNT_W'(1);
              end else begin
                phase <= PH_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R10: the data line moves only while the clock line is low
  a_r10_oe_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_s);

  // R6: an unread byte and its valid flag are held
  a_r6_rx_hold: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R9: STOP returns the block to idle
  a_r9_stop_idle: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (!st_busy && !st_addressed && !sda_oe));

  // R9: never pulls the line outside a transfer
  a_r9_idle_released: assert property (@(posedge clk) disable iff (rst)
    !st_busy |-> !sda_oe);

  // R7: bytes are only taken when addressed for reading
  a_r7_txready_read: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> (st_read && st_addressed));
endmodule

// File: tb/tb_i2c_tgt.sv
`timescale 1ns/1ps
module tb_i2c_tgt;
  localparam int Q = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [9:0] cfg_own_addr = 10'h02A;
  logic cfg_addr10 = 1'b0;
  logic cfg_gc_en = 1'b0;
  logic cfg_ack_en = 1'b1;
  logic [7:0] rx_data;
  logic rx_valid;
  logic rx_ready = 1'b1;
  logic [7:0] tx_data = 8'h00;
  logic tx_valid = 1'b0;
  logic tx_ready;
  logic st_busy, st_addressed, st_read, st_gc;
  wire  sda_bus = sda_m & ~sda_oe;

  int checks = 0;
  int errors = 0;
  int rx_cnt = 0;
  int tx_cnt = 0;
  int oe_bad = 0;
  logic [7:0] rx_last = 8'h00;
  logic oe_prev = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  i2c_tgt dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .cfg_own_addr(cfg_own_addr), .cfg_addr10(cfg_addr10), .cfg_gc_en(cfg_gc_en),
    .cfg_ack_en(cfg_ack_en), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .st_busy(st_busy), .st_addressed(st_addressed),
    .st_read(st_read), .st_gc(st_gc)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid && rx_ready) begin
        rx_cnt++;
        rx_last = rx_data;
      end
      if (tx_ready) tx_cnt++;
      if (sda_oe !== oe_prev && scl_m) oe_bad++;
    end
    oe_prev = sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic m_start();
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b0; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic m_stop();
    sda_m = 1'b0; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b1; qwait();
  endtask

  task automatic m_bit(input logic b, output logic r);
    sda_m = b; qwait();
    scl_m = 1'b1; qwait();
    r = sda_bus; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic m_wbyte(input logic [7:0] d, output logic acked);
    logic r;
    for (int i = 7; i >= 0; i--) m_bit(d[i], r);
    m_bit(1'b1, r);
    acked = ~r;
  endtask

  task automatic m_rbyte(output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      m_bit(1'b1, r);
      d[i] = r;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack, r;
    logic [7:0] d;
    int n;
    repeat (6) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({sda_oe, st_busy, st_addressed, st_read, st_gc, rx_valid, tx_ready} == 7'b0,
        "R1", {sda_oe, st_busy, st_addressed, st_read, st_gc, rx_valid, tx_ready}, 0);

    // R2 / R3 sweep of every 7-bit address, broadcast off and on
    for (int g = 0; g < 2; g++) begin
      cfg_gc_en = g[0];
      for (int a = 0; a < 128; a++) begin
        m_start();
        m_wbyte({a[6:0], 1'b0}, ack);
        if (a == 0) begin
          chk(ack == g[0], "R3", ack, g[0]);
          chk(st_gc == g[0], "R3", st_gc, g[0]);
        end else begin
          chk(ack == (a == 8'h2A), "R2", ack, (a == 8'h2A));
        end
        m_stop();
      end
    end

    // R4 / R3 sweep of every first byte in 10-bit mode
    cfg_addr10 = 1'b1;
    cfg_own_addr = 10'h2B5;
    cfg_gc_en = 1'b1;
    for (int b = 0; b < 256; b++) begin
      m_start();
      m_wbyte(b[7:0], ack);
      chk(ack == (b == 8'hF4 || b == 0), "R4", ack, (b == 8'hF4 || b == 0));
      m_stop();
    end
    chk(!st_busy && !st_addressed, "R9", {st_busy, st_addressed}, 0);

    // R4 full 10-bit write with a data byte, then a wrong low byte
    n = rx_cnt;
    m_start();
    m_wbyte(8'hF4, ack);
    chk(ack && !st_addressed, "R4", {ack, st_addressed}, 2);
    m_wbyte(8'hB5, ack);
    chk(ack && st_addressed, "R4", {ack, st_addressed}, 3);
    m_wbyte(8'h77, ack);
    chk(ack && rx_cnt == n + 1 && rx_last == 8'h77, "R6", rx_last, 8'h77);
    m_stop();
    m_start();
    m_wbyte(8'hF4, ack);
    m_wbyte(8'hB4, ack);
    chk(!ack && !st_addressed, "R4", {ack, st_addressed}, 0);
    m_stop();

    // R5 10-bit read after a repeated START
    m_start();
    m_wbyte(8'hF4, ack);
    m_wbyte(8'hB5, ack);
    m_start();
    tx_data = 8'h3C;
    tx_valid = 1'b1;
    n = tx_cnt;
    m_wbyte(8'hF5, ack);
    chk(ack && st_read && st_addressed, "R5", {ack, st_read, st_addressed}, 7);
    m_rbyte(d);
    tx_valid = 1'b0;
    chk(d == 8'h3C, "R5", d, 8'h3C);
    m_bit(1'b1, r);
    m_stop();
    chk(tx_cnt == n + 1, "R7", tx_cnt - n, 1);

    // R7 7-bit read: taken byte, filler byte, stop after no-acknowledge
    cfg_addr10 = 1'b0;
    cfg_own_addr = 10'h02A;
    cfg_gc_en = 1'b0;
    tx_data = 8'h96;
    tx_valid = 1'b1;
    n = tx_cnt;
    m_start();
    m_wbyte(8'h55, ack);
    chk(ack && st_read, "R7", {ack, st_read}, 3);
    m_rbyte(d);
    chk(d == 8'h96, "R7", d, 8'h96);
    tx_valid = 1'b0;
    m_bit(1'b0, r);
    m_rbyte(d);
    chk(d == 8'hFF, "R7", d, 8'hFF);
    tx_valid = 1'b1;
    m_bit(1'b1, r);
    m_rbyte(d);
    chk(d == 8'hFF && sda_oe == 1'b0, "R7", d, 8'hFF);
    chk(tx_cnt == n + 1, "R7", tx_cnt - n, 1);
    tx_valid = 1'b0;
    m_stop();

    // R6 receive with the slot held full
    rx_ready = 1'b0;
    n = rx_cnt;
    m_start();
    m_wbyte(8'h54, ack);
    chk(ack && st_addressed && !st_read, "R2", {ack, st_addressed, st_read}, 6);
    m_wbyte(8'h5A, ack);
    chk(ack && rx_valid && rx_data == 8'h5A, "R6", rx_data, 8'h5A);
    m_wbyte(8'hC3, ack);
    chk(!ack && rx_data == 8'h5A, "R6", {ack, rx_data}, 8'h5A);
    rx_ready = 1'b1;
    repeat (2) @(negedge clk);
    chk(!rx_valid && rx_cnt == n + 1, "R6", rx_valid, 0);
    m_wbyte(8'h3C, ack);
    chk(ack && rx_last == 8'h3C && rx_cnt == n + 2, "R6", rx_last, 8'h3C);
    m_stop();

    // R8 acknowledge disabled
    cfg_ack_en = 1'b0;
    n = rx_cnt;
    m_start();
    m_wbyte(8'h54, ack);
    chk(!ack && st_addressed, "R8", {ack, st_addressed}, 1);
    m_wbyte(8'h11, ack);
    chk(!ack && rx_cnt == n + 1 && rx_last == 8'h11, "R8", rx_last, 8'h11);
    m_stop();
    cfg_ack_en = 1'b1;

    // R9 START in mid-byte, then STOP in mid-byte
    n = rx_cnt;
    m_start();
    m_wbyte(8'h54, ack);
    m_bit(1'b1, r); m_bit(1'b0, r); m_bit(1'b1, r); m_bit(1'b0, r);
    m_start();
    chk(!st_addressed && st_busy, "R9", {st_addressed, st_busy}, 1);
    m_wbyte(8'h56, ack);
    chk(!ack && !st_addressed && rx_cnt == n, "R9", {ack, st_addressed}, 0);
    m_stop();
    m_start();
    m_wbyte(8'h54, ack);
    m_bit(1'b0, r); m_bit(1'b1, r); m_bit(1'b1, r);
    m_stop();
    repeat (2) @(negedge clk);
    chk(!st_busy && !st_addressed && !sda_oe && rx_cnt == n, "R9",
        {st_busy, st_addressed, sda_oe}, 0);

    // R10 SDA never moved while SCL was high
    chk(oe_bad == 0, "R10", oe_bad, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule